// File: doc/BRIEF.md
# Synchronous Burst SRAM Cycle Controller

This block is the control and data path of a small synchronous burst memory (16 words of 64 bits by default). On every rising clock edge it samples three chip enables, two burst-start strobes (one from the processor, one from the cache controller), an advance strobe and the write inputs. From these it sorts the cycle into unselected, begin, continue or suspend, for reads and for writes. A 2-bit burst sequencer steps through a four-word group in linear or in interleaved (XOR) order. Writes are masked per byte lane. Read data passes through a registered address stage and then a registered output stage, so the first word of a burst arrives in the third clock and each further word one clock later.

The two strobes are qualified differently. The processor strobe is ignored outright while the first enable is inactive. The controller strobe is honoured, but then gives an unselected cycle. The second and third enables count only in cycles where a strobe is seen. Byte lane enables are taken in the same cycle as the write data. A sleep input freezes the block while keeping its contents. After sleep is released, a fixed recovery window must pass before any access can happen. The output enable gates the read bus without a clock.

The read side is a source with no back-pressure. `rd_valid` marks a word in exactly one cycle, and there is no ready input, so the consumer must take each word in the cycle it is offered. The tristate pad is modelled by `rd_drive`: while it is low, `rd_data` is held at zero.

Top module: `sync_burst_sram_ctl`

## Requirements
- R1: `out_en_n` acts without a clock. While it is high, `rd_drive` is 0 and `rd_data` is 0. While it is low, `rd_drive` equals `rd_valid`, and `rd_data` carries the registered word whenever `rd_valid` is 1.
- R2: A begin read happens at edge T when `en_a_n`=0, `en_b`=1, `en_c_n`=0 and `strobe_cpu_n`=0, whatever the write inputs are. It reads `addr`, and `rd_valid` with that word is presented after edge T+1.
- R3: While `en_a_n`=1, `strobe_cpu_n` has no effect. In that state `strobe_ctl_n`=0 makes an unselected cycle.
- R4: A cycle in which a strobe is seen but `en_b`=0 or `en_c_n`=1 is unselected. `rd_valid` is 0 after that edge, even when a read was already in flight. Outside strobe cycles, `en_b` and `en_c_n` are ignored.
- R5: A begin write happens when the chip is selected, `strobe_ctl_n`=0, the processor strobe is not seen, and a write is asserted. The write goes to `addr` with that cycle's data. With no write asserted, the same cycle is a begin read.
- R6: `wr_all_n`=0 writes all lanes. Otherwise `wr_bytes_n`=0 writes each lane i for which `lane_en_n[i]`=0; lane i covers `wr_data[8i+7:8i]`. `wr_bytes_n`=0 with every lane enable high counts as a read.
- R7: When no strobe is seen and a burst is active, `step_n`=0 is a continue cycle at the next burst address and `step_n`=1 is a suspend cycle at the current address. The cycle's write inputs decide between read and write.
- R8: The burst address keeps the upper `addr` bits of the start address. Its low two bits are start XOR count when `order_xor`=1, and (start + count) mod 4 when `order_xor`=0.
- R9: A begin read followed by continue reads gives one valid word per clock after the first (3-1-1-1).
- R10: An unselected cycle ends the burst. Later cycles with no strobe neither read nor write until a new begin cycle.
- R11: At every edge where `sleep`=1, all other inputs are ignored, no write happens, the contents are kept, and `rd_valid` is 0 after that edge.
- R12: For `WAKE_CYCLES` edges after `sleep` returns to 0, all inputs are ignored, so no strobe starts an access.
- R13: After reset, `rd_valid`=0, no burst is active and every word reads as zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| sleep | input | 1 | Low-power hold request |
| order_xor | input | 1 | 1 = interleaved burst order, 0 = linear order; static |
| en_a_n | input | 1 | First chip enable, active low; also masks the processor strobe |
| en_b | input | 1 | Second chip enable, active high; sampled with a strobe |
| en_c_n | input | 1 | Third chip enable, active low; sampled with a strobe |
| strobe_cpu_n | input | 1 | Processor burst-start strobe, active low |
| strobe_ctl_n | input | 1 | Controller burst-start strobe, active low |
| step_n | input | 1 | Burst advance, active low |
| wr_all_n | input | 1 | Write all lanes, active low |
| wr_bytes_n | input | 1 | Write the enabled lanes, active low |
| lane_en_n | input | LANES | Per-lane write enables, active low |
| addr | input | AW | Start address |
| wr_data | input | DW | Write data |
| out_en_n | input | 1 | Output enable, active low, unclocked |
| rd_data | output | DW | Read word, zero while not driven |
| rd_valid | output | 1 | Read word present this cycle |
| rd_drive | output | 1 | Bus driven (valid and enabled) |

## Verification
The checker watches several properties on every cycle. It confirms that the bus stays silent while the output enable is off. It confirms that an unselected strobe cycle, whether from a failed second or third enable or from the controller strobe with the first enable off, drops `rd_valid` at the next edge. It confirms that sleep and the recovery window keep `rd_valid` low, and that a clean begin read shows data two edges later. Burst ordering, lane masking, a write of no lanes turning into a read, the end of a burst after deselection, and contents surviving sleep all depend on the stored data. The bench's reference model shows these through its directed and random scenarios.

// File: rtl/sbc_pkg.sv
package sbc_pkg;

  typedef enum logic [2:0] {
    CYC_IDLE,
    CYC_UNSEL,
    CYC_BEGIN_RD,
    CYC_BEGIN_WR,
    CYC_CONT,
    CYC_SUSP,
    CYC_HUSH
  } cyc_e;

  localparam int unsigned GROUP_BITS = 2;

  function automatic logic [GROUP_BITS-1:0] burst_pos(
    input logic [GROUP_BITS-1:0] start,
    input logic [GROUP_BITS-1:0] count,
    input logic                  use_xor
  );
    logic [GROUP_BITS-1:0] pos;
    if (use_xor) pos = start ^ count;
    else         pos = start + count;
    return pos;
  endfunction

endpackage

// File: rtl/sbc_wake_timer.sv
module sbc_wake_timer #(
  parameter int unsigned WAKE_CYCLES = 4
) (
  input  logic clk,
  input  logic rst_n,
  input  logic sleep,
  output logic quiet
);
  localparam int unsigned CW = $clog2(WAKE_CYCLES + 1);

  logic [CW-1:0] remain_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                remain_q <= '0;
    else if (sleep)            remain_q <= CW'(WAKE_CYCLES);
    else if (remain_q != '0)   remain_q <= remain_q - 1'b1;
  end

  assign quiet = sleep || (remain_q != '0);
endmodule

// File: rtl/sbc_cycle_decode.sv
module sbc_cycle_decode
  import sbc_pkg::*;
#(
  parameter int unsigned LANES = 8
) (
  input  logic             quiet,
  input  logic             burst_act,
  input  logic             en_a_n,
  input  logic             en_b,
  input  logic             en_c_n,
  input  logic             strobe_cpu_n,
  input  logic             strobe_ctl_n,
  input  logic             step_n,
  input  logic             wr_all_n,
  input  logic             wr_bytes_n,
  input  logic [LANES-1:0] lane_en_n,
  output cyc_e             kind,
  output logic             do_rd,
  output logic             do_wr,
  output logic [LANES-1:0] lane_mask
);
  logic cpu_go;
  logic strobe_seen;
  logic chip_ok;
  logic wr_any;

  assign cpu_go      = !en_a_n && !strobe_cpu_n;
  assign strobe_seen = cpu_go || !strobe_ctl_n;
  assign chip_ok     = !en_a_n && en_b && !en_c_n;
  assign wr_any      = !wr_all_n || (!wr_bytes_n && (lane_en_n != '1));

  always_comb begin
    if (!wr_all_n)       lane_mask = '1;
    else if (!wr_bytes_n) lane_mask = ~lane_en_n;
    else                 lane_mask = '0;
  end

  always_comb begin
    if (quiet)                 kind = CYC_HUSH;
    else if (strobe_seen) begin
      if (!chip_ok)            kind = CYC_UNSEL;
      else if (cpu_go || !wr_any) kind = CYC_BEGIN_RD;
      else                     kind = CYC_BEGIN_WR;
    end
    else if (burst_act)        kind = step_n ? CYC_SUSP : CYC_CONT;
    else                       kind = CYC_IDLE;
  end

  always_comb begin
    do_rd = 1'b0;
    do_wr = 1'b0;
    unique case (kind)
      CYC_BEGIN_RD:      do_rd = 1'b1;
      CYC_BEGIN_WR:      do_wr = 1'b1;
      CYC_CONT, CYC_SUSP: begin
        do_wr = wr_any;
        do_rd = !wr_any;
      end
      default: ;
    endcase
  end
endmodule

// File: rtl/sbc_burst_seq.sv
module sbc_burst_seq
  import sbc_pkg::*;
#(
  parameter int unsigned AW = 4
) (
  input  logic          clk,
  input  logic          rst_n,
  input  cyc_e          kind,
  input  logic          order_xor,
  input  logic [AW-1:0] addr,
  output logic [AW-1:0] acc_addr,
  output logic          burst_act
);
  localparam int unsigned GB = GROUP_BITS;

  logic [AW-1:0] base_q;
  logic [GB-1:0] count_q;
  logic [GB-1:0] count_use;

  always_comb begin
    count_use = (kind == CYC_CONT) ? count_q + 1'b1 : count_q;
    if (kind == CYC_BEGIN_RD || kind == CYC_BEGIN_WR)
      acc_addr = addr;
    else
      acc_addr = {base_q[AW-1:GB], burst_pos(base_q[GB-1:0], count_use, order_xor)};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      base_q    <= '0;
      count_q   <= '0;
      burst_act <= 1'b0;
    end else begin
      unique case (kind)
        CYC_BEGIN_RD, CYC_BEGIN_WR: begin
          base_q    <= addr;
          count_q   <= '0;
          burst_act <= 1'b1;
        end
        CYC_CONT:             count_q   <= count_use;
        CYC_UNSEL, CYC_HUSH:  burst_act <= 1'b0;
        default: ;
      endcase
    end
  end
endmodule

// File: rtl/sbc_array_path.sv
module sbc_array_path #(
  parameter int unsigned DW    = 64,
  parameter int unsigned DEPTH = 16,
  parameter int unsigned AW    = $clog2(DEPTH),
  parameter int unsigned LANES = DW / 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [AW-1:0]    acc_addr,
  input  logic             do_rd,
  input  logic             do_wr,
  input  logic             kill,
  input  logic [LANES-1:0] lane_mask,
  input  logic [DW-1:0]    wr_data,
  output logic [DW-1:0]    rd_word,
  output logic             rd_valid
);
  logic [AW-1:0] rd_addr_q;
  logic          rd_pend_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rd_addr_q <= '0;
      rd_pend_q <= 1'b0;
      rd_valid  <= 1'b0;
    end else begin
      rd_addr_q <= acc_addr;
      rd_pend_q <= do_rd;
      rd_valid  <= rd_pend_q && !kill;
    end
  end

  for (genvar g = 0; g < LANES; g++) begin : g_lane
    logic [7:0] bank [DEPTH];
    logic [7:0] out_q;

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        for (int d = 0; d < DEPTH; d++) bank[d] <= '0;
        out_q <= '0;
      end else begin
        if (do_wr && lane_mask[g]) bank[acc_addr] <= wr_data[8*g +: 8];
        out_q <= bank[rd_addr_q];
      end
    end

    assign rd_word[8*g +: 8] = out_q;
  end
endmodule

// File: rtl/sync_burst_sram_ctl.sv
module sync_burst_sram_ctl
  import sbc_pkg::*;
#(
  parameter int unsigned DW          = 64,
  parameter int unsigned DEPTH       = 16,
  parameter int unsigned WAKE_CYCLES = 4,
  parameter int unsigned AW          = $clog2(DEPTH),
  parameter int unsigned LANES       = DW / 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             sleep,
  input  logic             order_xor,
  input  logic             en_a_n,
  input  logic             en_b,
  input  logic             en_c_n,
  input  logic             strobe_cpu_n,
  input  logic             strobe_ctl_n,
  input  logic             step_n,
  input  logic             wr_all_n,
  input  logic             wr_bytes_n,
  input  logic [LANES-1:0] lane_en_n,
  input  logic [AW-1:0]    addr,
  input  logic [DW-1:0]    wr_data,
  input  logic             out_en_n,
  output logic [DW-1:0]    rd_data,
  output logic             rd_valid,
  output logic             rd_drive
);
  logic             quiet;
  logic             burst_act;
  cyc_e             kind;
  logic             do_rd;
  logic             do_wr;
  logic [LANES-1:0] lane_mask;
  logic [AW-1:0]    acc_addr;
  logic [DW-1:0]    rd_word;
  logic             kill;

  sbc_wake_timer #(.WAKE_CYCLES(WAKE_CYCLES)) i_wake (
    .clk   (clk),
    .rst_n (rst_n),
    .sleep (sleep),
    .quiet (quiet)
  );

  sbc_cycle_decode #(.LANES(LANES)) i_decode (
    .quiet        (quiet),
    .burst_act    (burst_act),
    .en_a_n       (en_a_n),
    .en_b         (en_b),
    .en_c_n       (en_c_n),
    .strobe_cpu_n (strobe_cpu_n),
    .strobe_ctl_n (strobe_ctl_n),
    .step_n       (step_n),
    .wr_all_n     (wr_all_n),
    .wr_bytes_n   (wr_bytes_n),
    .lane_en_n    (lane_en_n),
    .kind         (kind),
    .do_rd        (do_rd),
    .do_wr        (do_wr),
    .lane_mask    (lane_mask)
  );

  sbc_burst_seq #(.AW(AW)) i_seq (
    .clk       (clk),
    .rst_n     (rst_n),
    .kind      (kind),
    .order_xor (order_xor),
    .addr      (addr),
    .acc_addr  (acc_addr),
    .burst_act (burst_act)
  );

  assign kill = (kind == CYC_UNSEL) || (kind == CYC_HUSH);

  sbc_array_path #(.DW(DW), .DEPTH(DEPTH), .AW(AW), .LANES(LANES)) i_array (
    .clk       (clk),
    .rst_n     (rst_n),
    .acc_addr  (acc_addr),
    .do_rd     (do_rd),
    .do_wr     (do_wr),
    .kill      (kill),
    .lane_mask (lane_mask),
    .wr_data   (wr_data),
    .rd_word   (rd_word),
    .rd_valid  (rd_valid)
  );

  assign rd_drive = rd_valid && !out_en_n;
  assign rd_data  = rd_drive ? rd_word : '0;
endmodule

// File: rtl/sbc_checker.sv
module sbc_checker #(
  parameter int unsigned DW          = 64,
  parameter int unsigned WAKE_CYCLES = 4
) (
  input logic          clk,
  input logic          rst_n,
  input logic          sleep,
  input logic          en_a_n,
  input logic          en_b,
  input logic          en_c_n,
  input logic          strobe_cpu_n,
  input logic          strobe_ctl_n,
  input logic          out_en_n,
  input logic [DW-1:0] rd_data,
  input logic          rd_valid,
  input logic          rd_drive
);
  localparam int unsigned CW = $clog2(WAKE_CYCLES + 1);

  logic [CW-1:0] hush_cnt;
  logic          seen;
  logic          chip_ok;
  logic          unsel_now;
  logic          clean_rd;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)               hush_cnt <= '0;
    else if (sleep)           hush_cnt <= CW'(WAKE_CYCLES);
    else if (hush_cnt != '0)  hush_cnt <= hush_cnt - 1'b1;
  end

  assign seen      = (!en_a_n && !strobe_cpu_n) || !strobe_ctl_n;
  assign chip_ok   = !en_a_n && en_b && !en_c_n;
  assign unsel_now = seen && !chip_ok;
  assign clean_rd  = !en_a_n && !strobe_cpu_n && chip_ok && !sleep && (hush_cnt == '0);

  a_r1_bus_silent: assert property (@(posedge clk) disable iff (!rst_n)
    out_en_n |-> (rd_data == '0 && !rd_drive));

  a_r3_ctl_strobe_unsel: assert property (@(posedge clk) disable iff (!rst_n)
    (en_a_n && !strobe_ctl_n) |=> !rd_valid);

  a_r4_deselect_drops: assert property (@(posedge clk) disable iff (!rst_n)
    unsel_now |=> !rd_valid);

  a_r11_sleep_silent: assert property (@(posedge clk) disable iff (!rst_n)
    sleep |=> !rd_valid);

  a_r12_wake_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (hush_cnt != '0) |=> !rd_valid);

  a_r2_first_word: assert property (@(posedge clk) disable iff (!rst_n)
    clean_rd ##1 (!sleep && !unsel_now) |=> rd_valid);
endmodule

bind sync_burst_sram_ctl sbc_checker #(.DW(DW), .WAKE_CYCLES(WAKE_CYCLES)) i_sbc_checker (
  .clk          (clk),
  .rst_n        (rst_n),
  .sleep        (sleep),
  .en_a_n       (en_a_n),
  .en_b         (en_b),
  .en_c_n       (en_c_n),
  .strobe_cpu_n (strobe_cpu_n),
  .strobe_ctl_n (strobe_ctl_n),
  .out_en_n     (out_en_n),
  .rd_data      (rd_data),
  .rd_valid     (rd_valid),
  .rd_drive     (rd_drive)
);

// File: tb/test_sync_burst_sram_ctl.sv
module test_sync_burst_sram_ctl;
  localparam int DW = 64, DEPTH = 16, AW = 4, LANES = 8, WAKE = 4;

  logic clk = 1'b0;
  always #10 clk = ~clk;

  logic rst_n, sleep, order_xor, en_a_n, en_b, en_c_n;
  logic strobe_cpu_n, strobe_ctl_n, step_n, wr_all_n, wr_bytes_n, out_en_n;
  logic [LANES-1:0] lane_en_n;
  logic [AW-1:0]    addr;
  logic [DW-1:0]    wr_data;
  logic [DW-1:0]    rd_data;
  logic             rd_valid, rd_drive;

  sync_burst_sram_ctl #(.DW(DW), .DEPTH(DEPTH), .WAKE_CYCLES(WAKE)) i_sync_burst_sram_ctl (
    .clk(clk), .rst_n(rst_n), .sleep(sleep), .order_xor(order_xor),
    .en_a_n(en_a_n), .en_b(en_b), .en_c_n(en_c_n),
    .strobe_cpu_n(strobe_cpu_n), .strobe_ctl_n(strobe_ctl_n), .step_n(step_n),
    .wr_all_n(wr_all_n), .wr_bytes_n(wr_bytes_n), .lane_en_n(lane_en_n),
    .addr(addr), .wr_data(wr_data), .out_en_n(out_en_n),
    .rd_data(rd_data), .rd_valid(rd_valid), .rd_drive(rd_drive)
  );

  int    checks = 0;
  int    errors = 0;
  string cur_req = "R13";

  logic [DW-1:0] m_mem [DEPTH];
  logic          m_act, m_pend, m_valid;
  logic [AW-1:0] m_base, m_paddr;
  logic [1:0]    m_cnt;
  logic [DW-1:0] m_data;
  int            m_wake;

  function automatic logic [AW-1:0] seq_addr(logic [AW-1:0] b, logic [1:0] c, logic x);
    logic [1:0] lo;
    lo = x ? (b[1:0] ^ c) : (b[1:0] + c);
    return {b[AW-1:2], lo};
  endfunction

  function automatic logic [DW-1:0] pattern(int i);
    return {32'(i) * 32'h0101_0101 + 32'h1357_9bdf, ~(32'(i) * 32'h0102_0304)};
  endfunction

  task automatic model_reset();
    for (int d = 0; d < DEPTH; d++) m_mem[d] = '0;
    m_act = 0; m_pend = 0; m_valid = 0; m_base = '0; m_paddr = '0;
    m_cnt = '0; m_data = '0; m_wake = 0;
  endtask

  task automatic model_edge();
    logic quiet, cpu_go, sseen, cok, wr_any, unsel, rd, wr, nv;
    logic [AW-1:0] a;
    logic [DW-1:0] nd;
    quiet = sleep || (m_wake != 0);
    nd = m_mem[m_paddr];
    if (sleep) m_wake = WAKE;
    else if (m_wake != 0) m_wake--;
    rd = 0; wr = 0; a = '0; nv = 0;
    if (quiet) begin
      m_act = 0;
    end else begin
      cpu_go = !en_a_n && !strobe_cpu_n;
      sseen  = cpu_go || !strobe_ctl_n;
      cok    = !en_a_n && en_b && !en_c_n;
      wr_any = !wr_all_n || (!wr_bytes_n && lane_en_n != '1);
      unsel  = sseen && !cok;
      nv     = m_pend && !unsel;
      if (sseen) begin
        if (cok) begin
          m_act = 1; m_base = addr; m_cnt = '0; a = addr;
          if (cpu_go || !wr_any) rd = 1; else wr = 1;
        end else m_act = 0;
      end else if (m_act) begin
        if (!step_n) m_cnt++;
        a = seq_addr(m_base, m_cnt, order_xor);
        if (wr_any) wr = 1; else rd = 1;
      end
    end
    if (wr)
      for (int l = 0; l < LANES; l++)
        if (!wr_all_n || !lane_en_n[l]) m_mem[a][8*l +: 8] = wr_data[8*l +: 8];
    m_valid = nv;
    m_data  = nd;
    m_pend  = rd;
    if (rd) m_paddr = a;
  endtask

  task automatic check_outputs();
    logic          ed;
    logic [DW-1:0] edata;
    ed    = m_valid && !out_en_n;
    edata = ed ? m_data : '0;
    checks++;
    if (rd_valid !== m_valid || rd_drive !== ed || rd_data !== edata) begin
      errors++;
      $display("FAIL %s: valid=%0b drive=%0b data=%h expected valid=%0b drive=%0b data=%h",
               cur_req, rd_valid, rd_drive, rd_data, m_valid, ed, edata);
    end
  endtask

  task automatic tick();
    @(posedge clk);
    model_edge();
    @(negedge clk);
    check_outputs();
  endtask

  task automatic set_idle();
    sleep = 0; en_a_n = 0; en_b = 1; en_c_n = 0;
    strobe_cpu_n = 1; strobe_ctl_n = 1; step_n = 1;
    wr_all_n = 1; wr_bytes_n = 1; lane_en_n = '1; out_en_n = 0;
    addr = '0; wr_data = '0;
  endtask

  task automatic drop();
    set_idle(); en_a_n = 1; strobe_ctl_n = 0; tick(); set_idle(); en_a_n = 1;
  endtask

  task automatic cpu_read(logic [AW-1:0] a);
    set_idle(); strobe_cpu_n = 0; addr = a; tick(); set_idle();
  endtask

  task automatic ctl_write(logic [AW-1:0] a, logic [DW-1:0] d);
    set_idle(); strobe_ctl_n = 0; wr_all_n = 0; addr = a; wr_data = d; tick(); set_idle();
  endtask

  task automatic steps(int n, logic adv);
    for (int k = 0; k < n; k++) begin set_idle(); step_n = !adv; tick(); end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: run did not finish, expected end before limit");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    void'($urandom(32'd20240611));
    set_idle(); order_xor = 0; rst_n = 0;
    model_reset();
    repeat (3) @(negedge clk);
    rst_n = 1;
    cur_req = "R13"; check_outputs();
    cpu_read(4'd9); tick(); cur_req = "R13"; tick();

    cur_req = "R5";
    for (int i = 0; i < DEPTH; i++) ctl_write(AW'(i), pattern(i));
    drop();

    cur_req = "R2";
    set_idle(); strobe_cpu_n = 0; wr_all_n = 0; addr = 4'd7; wr_data = '1; tick();
    set_idle(); tick(); tick();
    drop();

    cur_req = "R8"; order_xor = 0;
    cpu_read(4'd5); cur_req = "R9"; steps(3, 1); tick(); drop();
    cur_req = "R8"; order_xor = 1;
    cpu_read(4'd14); cur_req = "R9"; steps(3, 1); steps(2, 1); tick(); drop();
    order_xor = 0;

    cur_req = "R7";
    cpu_read(4'd2); steps(2, 0); steps(1, 1);
    set_idle(); wr_bytes_n = 0; lane_en_n = 8'hF0; wr_data = {DW{1'b1}}; tick();
    set_idle(); tick(); tick(); drop();

    cur_req = "R6";
    set_idle(); strobe_ctl_n = 0; wr_bytes_n = 0; lane_en_n = 8'b0101_1010;
    addr = 4'd3; wr_data = 64'hA1B2_C3D4_E5F6_0718; tick();
    set_idle(); strobe_ctl_n = 0; wr_bytes_n = 0; lane_en_n = 8'hFF; addr = 4'd3;
    wr_data = '0; tick(); set_idle(); tick(); tick(); drop();

    cur_req = "R3";
    cpu_read(4'd8); set_idle(); en_a_n = 1; strobe_cpu_n = 0; addr = 4'd0; tick();
    set_idle(); en_a_n = 1; strobe_cpu_n = 0; step_n = 0; tick();
    set_idle(); en_a_n = 1; strobe_ctl_n = 0; tick(); set_idle(); tick();

    cur_req = "R4";
    cpu_read(4'd10); set_idle(); en_b = 0; strobe_cpu_n = 0; tick(); tick();
    cpu_read(4'd11); set_idle(); en_c_n = 1; strobe_ctl_n = 0; tick(); tick();
    set_idle(); en_b = 0; en_c_n = 1; step_n = 0; tick(); tick();

    cur_req = "R10";
    cpu_read(4'd12); drop();
    set_idle(); en_a_n = 1; step_n = 0; wr_all_n = 0; wr_data = '0; tick(); tick();
    cpu_read(4'd12); tick(); tick(); drop();

    cur_req = "R1";
    cpu_read(4'd4); tick();
    out_en_n = 1; #2;
    checks++;
    if (rd_drive !== 1'b0 || rd_data !== '0) begin
      errors++;
      $display("FAIL R1: drive=%0b data=%h expected drive=0 data=0", rd_drive, rd_data);
    end
    out_en_n = 0; #2;
    checks++;
    if (rd_drive !== 1'b1 || rd_data !== m_data) begin
      errors++;
      $display("FAIL R1: drive=%0b data=%h expected drive=1 data=%h", rd_drive, rd_data, m_data);
    end
    @(negedge clk); drop();

    cur_req = "R11";
    cpu_read(4'd6);
    for (int k = 0; k < 3; k++) begin
      set_idle(); sleep = 1; strobe_ctl_n = 0; wr_all_n = 0; addr = 4'd6; wr_data = '0; tick();
    end
    cur_req = "R12";
    for (int k = 0; k < WAKE; k++) begin
      set_idle(); strobe_cpu_n = 0; addr = AW'(k); tick();
    end
    set_idle(); tick();
    cur_req = "R11"; cpu_read(4'd6); tick(); tick(); drop();

    cur_req = "R9";
    for (int seg = 0; seg < 2; seg++) begin
      order_xor = seg[0];
      for (int n = 0; n < 1500; n++) begin
        sleep        = ($urandom % 100) < 2;
        en_a_n       = ($urandom % 100) < 20;
        en_b         = ($urandom % 100) < 90;
        en_c_n       = ($urandom % 100) < 10;
        strobe_cpu_n = ($urandom % 100) >= 15;
        strobe_ctl_n = ($urandom % 100) >= 15;
        step_n       = $urandom % 2;
        wr_all_n     = ($urandom % 100) >= 15;
        wr_bytes_n   = ($urandom % 100) >= 30;
        lane_en_n    = LANES'($urandom);
        addr         = AW'($urandom);
        wr_data      = {$urandom, $urandom};
        out_en_n     = ($urandom % 100) < 15;
        tick();
      end
      set_idle(); sleep = 1; tick(); set_idle();
      for (int k = 0; k < WAKE; k++) tick();
    end

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule